// File: doc/BRIEF.md
# Host-Controller Interrupt Enable and Status Logic

This block collects event pulses from a host-controller core and turns them into one level interrupt. Each of seven event sources owns a sticky status bit. Each status bit has its own enable. A master enable then gates the combined result. Software reaches the block over a plain 32-bit register bus made of an address, write data, a write strobe and combinational read data. The bus has no handshake and no back-pressure: a write takes effect at the clock edge where the strobe is high, and read data follows the address in the same cycle.

The enable bits are never written directly. Writing ones to one address sets enable bits. Writing ones to a second address clears them. Zero bits written to either address leave the bit alone. Status bits are cleared by writing ones to them. Every scheduling-overrun pulse also advances a small wrapping counter that software can read.

Top module: `hci_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every status bit and the overrun count are 0, and `irq_o` is low.
- R2: A write to address 0x410 sets each enable bit whose write-data bit is 1. Bit 31 is the master enable and bits 6:0 are the source enables. Bits written as 0 keep their value, and nothing changes while `wr_i` is low.
- R3: A write to address 0x414 clears each enable bit whose write-data bit is 1, and bits written as 0 keep their value.
- R4: Reading 0x410 or 0x414 returns the enable bits at their write positions. Bits 30:7 always read 0, and writes to them have no effect.
- R5: A one-cycle pulse on `evt_i[k]` sets status bit k, and the bit stays set. The source positions are: 0 scheduling overrun, 1 writeback done, 2 start of frame, 3 resume detected, 4 unrecoverable error, 5 frame-number overflow, 6 root-hub status change.
- R6: Reading 0x40C returns the status bits in bits 6:0, with all other bits 0. Writing a 1 to a status bit at 0x40C clears it. If an event and a clear reach the same bit in the same cycle, the bit ends up set.
- R7: Each pulse on `evt_i[0]` increments a 2-bit count, read at 0x408 in bits 1:0. The count wraps from 3 to 0.
- R8: `irq_o` is high exactly when the master enable is set and at least one status bit has its enable set. It changes in the cycle after the register or event that caused it.
- R9: Any other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one write per cycle it is high |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| evt_i | input | 7 | Single-cycle event pulses from the core |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that the address input is stable and defined whenever the write strobe is high, and that event inputs are clean one-cycle pulses sampled on the rising edge. The bench drives all inputs on the falling edge and holds the strobe for exactly one cycle per write, so each write and each pulse is seen at a single rising edge. Some vectors deliberately put an overrun pulse and a status clear in the same cycle, so the event-wins rule is exercised together with the counter.

// File: rtl/hci_irq_pkg.sv
package hci_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int N_SRC  = 7;
  localparam int CNT_W  = 2;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h414;

  typedef enum int {
    SRC_SCHED_OVR = 0,
    SRC_WB_DONE   = 1,
    SRC_SOF       = 2,
    SRC_RESUME    = 3,
    SRC_UNRECOV   = 4,
    SRC_FN_OVF    = 5,
    SRC_HUB_CHG   = 6
  } src_idx_e;
endpackage

// File: rtl/hci_irq_enable.sv
module hci_irq_enable #(
  parameter int N_SRC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_hit_i,
  input  logic             clr_hit_i,
  input  logic [N_SRC-1:0] wsrc_i,
  input  logic             wmaster_i,
  output logic [N_SRC-1:0] en_o,
  output logic             master_o
);
  logic [N_SRC-1:0] en_q;
  logic             master_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      master_q <= 1'b0;
    end else if (set_hit_i) begin
      en_q     <= en_q | wsrc_i;
      master_q <= master_q | wmaster_i;
    end else if (clr_hit_i) begin
      en_q     <= en_q & ~wsrc_i;
      master_q <= master_q & ~wmaster_i;
    end
  end

  assign en_o     = en_q;
  assign master_o = master_q;

  // R2: ones written at the set address are set afterwards
  a_r2_set_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_hit_i |=> ((en_q & $past(wsrc_i)) == $past(wsrc_i)) && (master_q || !$past(wmaster_i)));
  // R2: zeros written at the set address leave bits untouched
  a_r2_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_hit_i |=> ((en_q & ~$past(wsrc_i)) == ($past(en_q) & ~$past(wsrc_i))));
  // R3: ones written at the clear address are cleared afterwards
  a_r3_clr_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit_i |=> ((en_q & $past(wsrc_i)) == '0) && !(master_q && $past(wmaster_i)));
  // R2: nothing changes without a hit
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_hit_i && !clr_hit_i |=> $stable(en_q) && $stable(master_q));
endmodule

// File: rtl/hci_irq_status.sv
module hci_irq_status #(
  parameter int N_SRC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_hit_i,
  input  logic [N_SRC-1:0] wclr_i,
  output logic [N_SRC-1:0] sts_o
);
  logic [N_SRC-1:0] sts_q;
  logic [N_SRC-1:0] clr_mask;

  assign clr_mask = clr_hit_i ? wclr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_mask) | evt_i;
  end

  assign sts_o = sts_q;

  // R5 / R6: an event always lands, even against a clear
  a_r6_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));
  // R5: status bits are sticky without a clear
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_hit_i |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
  // R6: a cleared bit without an event reads back zero
  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit_i |=> ((sts_q & $past(wclr_i) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/hci_ovr_counter.sv
module hci_ovr_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R7: the count advances by one per pulse and wraps naturally
  a_r7_step_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));
  // R7: the count is still without a pulse
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/hci_irq_ctrl.sv
module hci_irq_ctrl
  import hci_irq_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int NS   = N_SRC,
  parameter int CW   = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NS-1:0] evt_i,
  output logic          irq_o
);
  localparam int MASTER_BIT = DW - 1;

  logic          set_hit, clr_hit, sts_hit;
  logic [NS-1:0] en, sts;
  logic          master;
  logic [CW-1:0] ovr_cnt;
  logic          unused_wdata;

  assign set_hit = wr_i && (addr_i == AW'(OFS_EN_SET));
  assign clr_hit = wr_i && (addr_i == AW'(OFS_EN_CLR));
  assign sts_hit = wr_i && (addr_i == AW'(OFS_STATUS));
  assign unused_wdata = ^wdata_i[MASTER_BIT-1:NS];

  hci_irq_enable #(.N_SRC(NS)) u_enable (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_hit_i (set_hit),
    .clr_hit_i (clr_hit),
    .wsrc_i    (wdata_i[NS-1:0]),
    .wmaster_i (wdata_i[MASTER_BIT]),
    .en_o      (en),
    .master_o  (master)
  );

  hci_irq_status #(.N_SRC(NS)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .clr_hit_i (sts_hit),
    .wclr_i    (wdata_i[NS-1:0]),
    .sts_o     (sts)
  );

  hci_ovr_counter #(.CNT_W(CW)) u_ovr_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (evt_i[SRC_SCHED_OVR]),
    .cnt_o  (ovr_cnt)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFS_EN_SET) || addr_i == AW'(OFS_EN_CLR)) begin
      rdata_o[NS-1:0]     = en;
      rdata_o[MASTER_BIT] = master;
    end else if (addr_i == AW'(OFS_STATUS)) begin
      rdata_o[NS-1:0] = sts;
    end else if (addr_i == AW'(OFS_COUNT)) begin
      rdata_o[CW-1:0] = ovr_cnt;
    end
  end

  assign irq_o = master && ((sts & en) != '0);

  // R8: no interrupt without the master enable
  a_r8_master_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master |-> !irq_o);
  // R8: an interrupt always has a pending status bit behind it
  a_r8_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts != '0));
  // R4: reserved enable bits read zero
  a_r4_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFS_EN_SET)) |-> (rdata_o[MASTER_BIT-1:NS] == '0));
endmodule

// File: tb/test_hci_irq_ctrl.sv
module test_hci_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [6:0]  evt;
    logic [11:0] chk_addr;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 12'h410, 32'h0000_0005, 7'h00, 12'h410, 32'h0000_0005, 1'b0, 4'd2}, // R2 set two bits
    '{1'b1, 12'h410, 32'h0000_0000, 7'h00, 12'h410, 32'h0000_0005, 1'b0, 4'd2}, // R2 zero keeps
    '{1'b1, 12'h410, 32'h8000_0002, 7'h00, 12'h410, 32'h8000_0007, 1'b0, 4'd2}, // R2 master on
    '{1'b1, 12'h414, 32'h0000_0001, 7'h00, 12'h414, 32'h8000_0006, 1'b0, 4'd3}, // R3 clear bit 0
    '{1'b1, 12'h410, 32'h7FFF_FF80, 7'h00, 12'h410, 32'h8000_0006, 1'b0, 4'd4}, // R4 reserved
    '{1'b0, 12'h000, 32'h0000_0000, 7'h01, 12'h40C, 32'h0000_0001, 1'b0, 4'd5}, // R5 overrun, disabled
    '{1'b0, 12'h000, 32'h0000_0000, 7'h04, 12'h40C, 32'h0000_0005, 1'b1, 4'd8}, // R8 enabled source
    '{1'b1, 12'h414, 32'h8000_0000, 7'h00, 12'h410, 32'h0000_0006, 1'b0, 4'd8}, // R8 master off
    '{1'b1, 12'h410, 32'h8000_0000, 7'h00, 12'h410, 32'h8000_0006, 1'b1, 4'd8}, // R8 master back
    '{1'b1, 12'h40C, 32'h0000_0004, 7'h00, 12'h40C, 32'h0000_0001, 1'b0, 4'd6}, // R6 w1c
    '{1'b1, 12'h40C, 32'h0000_0001, 7'h01, 12'h40C, 32'h0000_0001, 1'b0, 4'd6}, // R6 event wins
    '{1'b0, 12'h000, 32'h0000_0000, 7'h01, 12'h408, 32'h0000_0003, 1'b0, 4'd7}, // R7 count 3
    '{1'b0, 12'h000, 32'h0000_0000, 7'h01, 12'h408, 32'h0000_0000, 1'b0, 4'd7}, // R7 wrap
    '{1'b1, 12'h400, 32'hFFFF_FFFF, 7'h00, 12'h400, 32'h0000_0000, 1'b0, 4'd9}, // R9 unmapped
    '{1'b0, 12'h000, 32'h0000_0000, 7'h40, 12'h40C, 32'h0000_0041, 1'b0, 4'd5}, // R5 hub change
    '{1'b1, 12'h410, 32'h0000_0040, 7'h00, 12'h410, 32'h8000_0046, 1'b1, 4'd8}, // R8 late enable
    '{1'b0, 12'h410, 32'h0000_007F, 7'h00, 12'h410, 32'h8000_0046, 1'b1, 4'd2}, // R2 no strobe
    '{1'b1, 12'h40C, 32'hFFFF_FFFF, 7'h00, 12'h40C, 32'h0000_0000, 1'b0, 4'd6}  // R6 clear all
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic [31:0] rdata;
  logic [6:0]  evt = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hci_irq_ctrl i_hci_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic reset_check(input string tag);
    read_check(tag, 12'h410, 32'h0);
    read_check(tag, 12'h414, 32'h0);
    read_check(tag, 12'h40C, 32'h0);
    read_check(tag, 12'h408, 32'h0);
    check(tag, {31'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_check("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    reset_check("R1 after reset");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wr = VEC[i].wr; addr = VEC[i].addr; wdata = VEC[i].wdata; evt = VEC[i].evt;
      @(negedge clk);
      wr = 1'b0; evt = '0; wdata = '0;
      read_check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), VEC[i].chk_addr, VEC[i].exp_rd);
      check($sformatf("R%0d vec %0d irq", VEC[i].req, i), {31'h0, irq}, {31'h0, VEC[i].exp_irq});
    end

    // R8 directed: every source alone raises irq when enabled with master
    @(negedge clk); wr = 1'b1; addr = 12'h410; wdata = 32'h8000_007F;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); wr = 1'b0; evt = 7'(1 << k);
      @(negedge clk); evt = '0; #1;
      check($sformatf("R8 source %0d irq", k), {31'h0, irq}, 32'h1);
      wr = 1'b1; addr = 12'h40C; wdata = 32'h0000_007F;
      @(negedge clk); wr = 1'b0; #1;
      check($sformatf("R6 source %0d cleared irq", k), {31'h0, irq}, 32'h0);
    end

    // R1 mid-run reset with state present
    @(negedge clk); evt = 7'h7F;
    @(negedge clk); evt = '0; rst_ni = 1'b0;
    @(negedge clk);
    reset_check("R1 mid-run reset");
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule